// File: doc/BRIEF.md
# Track Position Walker with End-of-Track Termination

This block follows a floppy-style data command from the moment its parameters are accepted until its result phase. After every completed sector it moves the cylinder, head and sector position forward, spots the end of the track and decides between three outcomes: carry on with the next sector, finish normally on terminal count, or stop abnormally because the transfer tried to run past the end of the track.

When the command ends, the block builds a seven-byte result record. It raises a one-cycle valid strobe together with an interrupt request, and it returns the main status byte to the ready state. Read and write commands that stop normally on the last sector of the track get one extra position step before the record is built, so the record names the sector that follows. Format and read-ID commands report their position as it stands.

Top module: `trk_walk`

## Requirements
- R1: After reset, status bytes `st0`, `st1` and `st2` are 0x00, `msr` is 0x80, and `irq`, `res_valid` and `dma_req_clr` are low.
- R2: `cmd_start` is taken only while no command is in progress. On acceptance, `msr` becomes 0x10 | `drv_act` (bit 4 means busy). A `cmd_start` during a command changes nothing.
- R3: A position step increments the sector, which is numbered from 1. Past `spt` the sector wraps to 1. With `multi_trk` set, the head then toggles and the cylinder advances only when the head goes from 1 to 0. With `multi_trk` clear, the cylinder advances and the head is unchanged. The cylinder never exceeds `max_cyl`.
- R4: A sector completion without terminal count and with the end-of-track flag clear performs a step. If, after that step, the head equals `multi_trk` and the sector equals `spt`, bit 7 of `st1` is set.
- R5: A sector completion with `term_cnt` high and the end-of-track flag clear performs a step. It then sets `st0` = (head << 2) | drive, where head is the stepped head, clears `st2`, and ends the command.
- R6: A sector completion without `term_cnt` while `st1` bit 7 is set performs no step. It sets `st0` = 0x40 | (head << 2) | drive, pulses `dma_req_clr` for one cycle, and ends the command.
- R7: A sector completion with `term_cnt` high while `st1` bit 7 is set performs no step. It sets `st0` = (head << 2) | drive. For a read (kind 00) or write (kind 01), the result stage then clears `st1` bit 7, performs one extra step and rewrites `st0` bit 2 with the new head.
- R8: For a format (kind 10) or read-ID (kind 11) command, no extra step is taken, and `st1` bit 7 is reported as it stands.
- R9: The result record has byte 0 at `res_bytes[7:0]`, in the order ST0, ST1, ST2, cylinder, head, sector, and then size code 2. `res_valid` is high for exactly one cycle, with `irq` high in the same cycle. The record stays unchanged until the next result.
- R10: At completion, `msr` becomes 0x80 | `drv_act` as captured at the start, and `st1` and `st2` read 0x00. `st0` keeps its final value.
- R11: `sec_done` has no effect while no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Accept a new command, one-cycle pulse |
| cmd_kind | input | 2 | 00 read, 01 write, 10 format, 11 read-ID |
| drv_sel | input | 2 | Drive number |
| multi_trk | input | 1 | Multitrack mode; also the head at which end of track is detected |
| start_cyl | input | CYL_W | Starting cylinder |
| start_head | input | 1 | Starting head |
| start_sec | input | SEC_W | Starting sector (1-based) |
| spt | input | SEC_W | Sectors per track of the media (at least 2) |
| max_cyl | input | CYL_W | Highest cylinder of the media |
| drv_act | input | 4 | Drive activity bits kept in the low nibble of `msr` |
| sec_done | input | 1 | One sector finished, one-cycle pulse |
| term_cnt | input | 1 | DMA terminal count, sampled with `sec_done` |
| st0 | output | 8 | Status byte 0 |
| st1 | output | 8 | Status byte 1, bit 7 is end of track |
| st2 | output | 8 | Status byte 2 |
| msr | output | 8 | Main status: bit 7 ready, bit 4 busy, bits 3:0 drive activity |
| dma_req_clr | output | 1 | Withdraw the DMA request, one-cycle pulse |
| irq | output | 1 | Interrupt request, set at result, cleared at next start |
| res_valid | output | 1 | Result record valid, one-cycle pulse |
| res_bytes | output | 56 | Seven result bytes, byte 0 in the low bits |

## Verification
`msr` shows the busy value at the first sample after the `cmd_start` edge. A `sec_done` sampled at edge k produces its new `st0`, `st1` and `dma_req_clr` just after edge k. `res_valid`, `irq`, the record and the cleared `st1`/`st2` appear just after edge k+1. The bench therefore drives on falling edges and checks the transfer outcome at the falling edge right after the `sec_done` edge. It checks the result stage one falling edge later and checks that the strobe has dropped one falling edge after that, so each result is read in the cycle its registers load.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_XFER = 2'b01,
    PH_RSLT = 2'b10
  } phase_e;

  localparam int unsigned EOT_BIT  = 7;
  localparam int unsigned RDY_BIT  = 7;
  localparam int unsigned BUSY_BIT = 4;
  localparam logic [1:0]  ST0_ABNORMAL = 2'b01;
endpackage

// File: rtl/tw_step.sv
module tw_step #(
  parameter int unsigned CYL_W = 8,
  parameter int unsigned SEC_W = 8
) (
  input  logic [CYL_W-1:0] cyl_i,
  input  logic             head_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             mt_i,
  input  logic [SEC_W-1:0] spt_i,
  input  logic [CYL_W-1:0] maxc_i,
  output logic [CYL_W-1:0] cyl_o,
  output logic             head_o,
  output logic [SEC_W-1:0] sec_o,
  output logic             eot_o
);
  logic bump;

  always_comb begin
    sec_o  = sec_i + SEC_W'(1);
    head_o = head_i;
    cyl_o  = cyl_i;
    bump   = 1'b0;
    if (sec_i >= spt_i) begin
      sec_o = SEC_W'(1);
      if (mt_i) begin
        head_o = ~head_i;
        bump   = head_i;
      end else begin
        bump = 1'b1;
      end
    end
    if (bump) begin
      cyl_o = (cyl_i >= maxc_i) ? maxc_i : cyl_i + CYL_W'(1);
    end
    eot_o = (mt_i == head_o) && (sec_o == spt_i);
  end

  // R3: a valid sector stays within 1..spt after a step, cylinder within max
  always_comb begin
    if (sec_i != '0 && sec_i <= spt_i && cyl_i <= maxc_i) begin
      p_sec_range_r3: assert (sec_o != '0 && sec_o <= spt_i && cyl_o <= maxc_i);
    end
  end
endmodule

// File: rtl/tw_pack.sv
module tw_pack #(
  parameter int unsigned CYL_W     = 8,
  parameter int unsigned SEC_W     = 8,
  parameter int unsigned NBYTES    = 7,
  parameter logic [7:0]  SIZE_CODE = 8'd2
) (
  input  logic [7:0]          s0_i,
  input  logic [7:0]          s1_i,
  input  logic [7:0]          s2_i,
  input  logic [CYL_W-1:0]    cyl_i,
  input  logic                head_i,
  input  logic [SEC_W-1:0]    sec_i,
  output logic [8*NBYTES-1:0] rec_o
);
  logic [7:0] fld [NBYTES];

  always_comb begin
    for (int i = 0; i < NBYTES; i++) fld[i] = 8'h00;
    fld[0] = s0_i;
    fld[1] = s1_i;
    fld[2] = s2_i;
    fld[3] = 8'(cyl_i);
    fld[4] = {7'b0, head_i};
    fld[5] = 8'(sec_i);
    fld[6] = SIZE_CODE;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign rec_o[8*g +: 8] = fld[g];
  end
endmodule

// File: rtl/trk_walk.sv
module trk_walk
  import tw_pkg::*;
#(
  parameter int unsigned CYL_W     = 8,
  parameter int unsigned SEC_W     = 8,
  parameter logic [7:0]  SIZE_CODE = 8'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [1:0]       cmd_kind,
  input  logic [1:0]       drv_sel,
  input  logic             multi_trk,
  input  logic [CYL_W-1:0] start_cyl,
  input  logic             start_head,
  input  logic [SEC_W-1:0] start_sec,
  input  logic [SEC_W-1:0] spt,
  input  logic [CYL_W-1:0] max_cyl,
  input  logic [3:0]       drv_act,
  input  logic             sec_done,
  input  logic             term_cnt,
  output logic [7:0]       st0,
  output logic [7:0]       st1,
  output logic [7:0]       st2,
  output logic [7:0]       msr,
  output logic             dma_req_clr,
  output logic             irq,
  output logic             res_valid,
  output logic [55:0]      res_bytes
);
  localparam int unsigned NBYTES = 7;
  localparam int unsigned REC_W  = 8 * NBYTES;

  phase_e           ph_q, ph_d;
  logic [CYL_W-1:0] cyl_q, cyl_d, maxc_q;
  logic             head_q, head_d, mt_q;
  logic [SEC_W-1:0] sec_q, sec_d, spt_q;
  logic [1:0]       drv_q, kind_q;
  logic [7:0]       st0_q, st0_d, st1_q, st1_d, st2_q, st2_d, msr_q, msr_d;
  logic             irq_q, irq_d, rv_q, rv_d, clr_q, clr_d;
  logic [REC_W-1:0] rec_q, rec_d, rec_w;
  logic             cfg_en, pos_en;

  logic [CYL_W-1:0] st_cyl;
  logic             st_head, st_eot;
  logic [SEC_W-1:0] st_sec;

  logic             fix;
  logic [CYL_W-1:0] r_cyl;
  logic             r_head;
  logic [SEC_W-1:0] r_sec;
  logic [7:0]       r_st0, r_st1;

  tw_step #(.CYL_W(CYL_W), .SEC_W(SEC_W)) u_step (
    .cyl_i (cyl_q), .head_i(head_q), .sec_i(sec_q),
    .mt_i  (mt_q),  .spt_i (spt_q),  .maxc_i(maxc_q),
    .cyl_o (st_cyl), .head_o(st_head), .sec_o(st_sec), .eot_o(st_eot)
  );

  // result-stage view: extra step for read/write ending normally on the last sector
  always_comb begin
    fix    = (kind_q[1] == 1'b0) && (st0_q[7:6] == 2'b00) && st1_q[EOT_BIT];
    r_cyl  = fix ? st_cyl  : cyl_q;
    r_head = fix ? st_head : head_q;
    r_sec  = fix ? st_sec  : sec_q;
    r_st1  = st1_q;
    r_st0  = st0_q;
    if (fix) begin
      r_st1[EOT_BIT] = 1'b0;
      r_st0[2]       = st_head;
    end
  end

  tw_pack #(.CYL_W(CYL_W), .SEC_W(SEC_W), .NBYTES(NBYTES), .SIZE_CODE(SIZE_CODE)) u_pack (
    .s0_i(r_st0), .s1_i(r_st1), .s2_i(st2_q),
    .cyl_i(r_cyl), .head_i(r_head), .sec_i(r_sec),
    .rec_o(rec_w)
  );

  always_comb begin
    ph_d   = ph_q;
    cyl_d  = cyl_q;
    head_d = head_q;
    sec_d  = sec_q;
    st0_d  = st0_q;
    st1_d  = st1_q;
    st2_d  = st2_q;
    msr_d  = msr_q;
    irq_d  = irq_q;
    rec_d  = rec_q;
    rv_d   = 1'b0;
    clr_d  = 1'b0;
    cfg_en = 1'b0;
    pos_en = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (cmd_start) begin
          cfg_en = 1'b1;
          pos_en = 1'b1;
          cyl_d  = start_cyl;
          head_d = start_head;
          sec_d  = start_sec;
          st1_d  = 8'h00;
          st2_d  = 8'h00;
          msr_d  = {3'b000, 1'b1, drv_act};
          irq_d  = 1'b0;
          ph_d   = PH_XFER;
        end
      end
      PH_XFER: begin
        if (sec_done) begin
          if (st1_q[EOT_BIT]) begin
            if (term_cnt) begin
              st0_d = {5'b0, head_q, drv_q};
              st2_d = 8'h00;
            end else begin
              st0_d = {ST0_ABNORMAL, 3'b0, head_q, drv_q};
              clr_d = 1'b1;
            end
            ph_d = PH_RSLT;
          end else begin
            pos_en = 1'b1;
            cyl_d  = st_cyl;
            head_d = st_head;
            sec_d  = st_sec;
            if (term_cnt) begin
              st0_d = {5'b0, st_head, drv_q};
              st2_d = 8'h00;
              ph_d  = PH_RSLT;
            end else begin
              st1_d[EOT_BIT] = st_eot;
            end
          end
        end
      end
      PH_RSLT: begin
        pos_en = 1'b1;
        cyl_d  = r_cyl;
        head_d = r_head;
        sec_d  = r_sec;
        st0_d  = r_st0;
        st1_d  = 8'h00;
        st2_d  = 8'h00;
        rec_d  = rec_w;
        rv_d   = 1'b1;
        irq_d  = 1'b1;
        msr_d  = {1'b1, 3'b000, msr_q[3:0]};
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      st0_q <= 8'h00;
      st1_q <= 8'h00;
      st2_q <= 8'h00;
      msr_q <= 8'h80;
      irq_q <= 1'b0;
      rv_q  <= 1'b0;
      clr_q <= 1'b0;
      rec_q <= '0;
    end else begin
      ph_q  <= ph_d;
      st0_q <= st0_d;
      st1_q <= st1_d;
      st2_q <= st2_d;
      msr_q <= msr_d;
      irq_q <= irq_d;
      rv_q  <= rv_d;
      clr_q <= clr_d;
      rec_q <= rec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q  <= 2'b00;
      kind_q <= 2'b00;
      mt_q   <= 1'b0;
      spt_q  <= '0;
      maxc_q <= '0;
    end else if (cfg_en) begin
      drv_q  <= drv_sel;
      kind_q <= cmd_kind;
      mt_q   <= multi_trk;
      spt_q  <= spt;
      maxc_q <= max_cyl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyl_q  <= '0;
      head_q <= 1'b0;
      sec_q  <= '0;
    end else if (pos_en) begin
      cyl_q  <= cyl_d;
      head_q <= head_d;
      sec_q  <= sec_d;
    end
  end

  assign st0         = st0_q;
  assign st1         = st1_q;
  assign st2         = st2_q;
  assign msr         = msr_q;
  assign irq         = irq_q;
  assign res_valid   = rv_q;
  assign dma_req_clr = clr_q;
  assign res_bytes   = rec_q;

  p_valid_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> irq);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  p_abn_st0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_clr |-> (st0[7:6] == ST0_ABNORMAL));
  p_done_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (msr[RDY_BIT] && !msr[BUSY_BIT] && st1 == 8'h00 && st2 == 8'h00));
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE && cmd_start) |=> $stable(drv_q) && $stable(kind_q));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !cmd_start) |=> ($stable(st0) && $stable(res_bytes)));
endmodule

// File: tb/trk_walk_tb.sv
`timescale 1ns/1ps
module trk_walk_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_start, multi_trk, start_head, sec_done, term_cnt;
  logic [1:0]  cmd_kind, drv_sel;
  logic [7:0]  start_cyl, start_sec, spt, max_cyl;
  logic [3:0]  drv_act;
  logic [7:0]  st0, st1, st2, msr;
  logic        dma_req_clr, irq, res_valid;
  logic [55:0] res_bytes;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // model state
  int m_c, m_h, m_s, m_st0;
  bit m_eot;

  always #2.5 clk = ~clk;

  trk_walk u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .drv_sel(drv_sel), .multi_trk(multi_trk), .start_cyl(start_cyl),
    .start_head(start_head), .start_sec(start_sec), .spt(spt), .max_cyl(max_cyl),
    .drv_act(drv_act), .sec_done(sec_done), .term_cnt(term_cnt),
    .st0(st0), .st1(st1), .st2(st2), .msr(msr), .dma_req_clr(dma_req_clr),
    .irq(irq), .res_valid(res_valid), .res_bytes(res_bytes)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3 model step
  task automatic m_step(input int mt, input int sp, input int mc);
    bit bump = 0;
    if (m_s >= sp) begin
      m_s = 1;
      if (mt != 0) begin bump = (m_h == 1); m_h = 1 - m_h; end
      else bump = 1;
    end else m_s = m_s + 1;
    if (bump) m_c = (m_c >= mc) ? mc : m_c + 1;
  endtask

  task automatic run_cmd(input int kind, input int c0, input int h0, input int s0,
                         input int drv, input int mt, input int sp, input int mc,
                         input int nib, input int n, input bit poke);
    bit done = 0;
    bit abn;
    logic [55:0] exp_rec;
    @(negedge clk);
    cmd_kind = 2'(kind); start_cyl = 8'(c0); start_head = 1'(h0); start_sec = 8'(s0);
    drv_sel = 2'(drv); multi_trk = 1'(mt); spt = 8'(sp); max_cyl = 8'(mc);
    drv_act = 4'(nib); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(msr == 8'(8'h10 | nib), "R2 busy msr", msr, 8'(8'h10 | nib));
    m_c = c0; m_h = h0; m_s = s0; m_eot = 0;
    if (poke) begin
      // R2: a second start mid-command must not reload anything
      start_cyl = 8'(mc); start_sec = 8'(sp); start_head = ~start_head;
      drv_sel = ~drv_sel; cmd_kind = ~cmd_kind; multi_trk = ~multi_trk;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      chk(msr == 8'(8'h10 | nib) && res_valid == 0, "R2 ignored start", msr, 8'(8'h10 | nib));
    end
    for (int i = 1; i <= n && !done; i++) begin
      bit tc = (i == n);
      sec_done = 1'b1; term_cnt = tc;
      @(negedge clk);
      sec_done = 1'b0; term_cnt = 1'b0;
      abn = 0;
      if (m_eot) begin
        done = 1;
        if (tc) m_st0 = (m_h << 2) | drv;
        else begin m_st0 = 8'h40 | (m_h << 2) | drv; abn = 1; end
      end else begin
        m_step(mt, sp, mc);
        if (tc) begin done = 1; m_st0 = (m_h << 2) | drv; end
        else m_eot = (mt == m_h) && (m_s == sp);
      end
      chk(dma_req_clr == abn, "R6 dma_req_clr", dma_req_clr, abn);
      chk(res_valid == 0, "R9 no early valid", res_valid, 0);
      if (done) chk(st0 == 8'(m_st0), abn ? "R6 abnormal st0" : "R5 normal st0", st0, 8'(m_st0));
      else chk(st1 == (m_eot ? 8'h80 : 8'h00), "R4 eot flag", st1, m_eot ? 8'h80 : 8'h00);
      @(negedge clk);
      if (done) begin
        if (kind < 2 && (m_st0 & 8'hC0) == 0 && m_eot) begin
          m_step(mt, sp, mc);
          m_eot = 0;
          m_st0 = (m_st0 & 8'hFB) | (m_h << 2);
        end
        exp_rec = {8'd2, 8'(m_s), 8'(m_h), 8'(m_c), 8'h00, (m_eot ? 8'h80 : 8'h00), 8'(m_st0)};
        chk(res_valid == 1 && irq == 1, "R9 valid with irq", {res_valid, irq}, 2'b11);
        chk(res_bytes == exp_rec, (kind < 2) ? "R7 R3 result record" : "R8 R3 result record",
            res_bytes, exp_rec);
        chk(msr == 8'(8'h80 | nib) && st1 == 0 && st2 == 0, "R10 completion status",
            {msr, st1, st2}, {8'(8'h80 | nib), 16'h0});
        chk(st0 == 8'(m_st0), "R10 st0 kept", st0, 8'(m_st0));
        @(negedge clk);
        chk(res_valid == 0 && irq == 1 && res_bytes == exp_rec, "R9 pulse and hold",
            {res_valid, irq}, 2'b01);
      end else begin
        chk(res_valid == 0, "R9 no valid mid-command", res_valid, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmd_start = 0; sec_done = 0; term_cnt = 0; cmd_kind = 0; drv_sel = 0;
    multi_trk = 0; start_cyl = 0; start_head = 0; start_sec = 1; spt = 2; max_cyl = 0; drv_act = 0;
    repeat (3) @(negedge clk);
    chk(st0 == 0 && st1 == 0 && st2 == 0, "R1 reset status", {st0, st1, st2}, 0);
    chk(msr == 8'h80 && irq == 0 && res_valid == 0 && dma_req_clr == 0, "R1 reset msr", msr, 8'h80);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: sector done while idle
    sec_done = 1; term_cnt = 1;
    @(negedge clk);
    sec_done = 0; term_cnt = 0;
    @(negedge clk);
    chk(res_valid == 0 && irq == 0 && st0 == 0 && msr == 8'h80, "R11 idle sec_done", {res_valid, st0}, 0);
    // R7: read ends normally on last sector of head 1
    run_cmd(0, 3, 1, 8, 2, 1, 9, 40, 4'h5, 2, 0);
    // R8: format, same position, no extra step
    run_cmd(2, 3, 1, 8, 1, 1, 9, 40, 4'h3, 2, 0);
    // R6: run past end of track
    run_cmd(0, 2, 0, 8, 3, 0, 9, 40, 4'h0, 3, 0);
    // R3: cylinder clamp
    run_cmd(1, 5, 0, 4, 0, 0, 4, 5, 4'hA, 1, 0);
    // R2: start during command ignored
    run_cmd(1, 7, 0, 2, 2, 1, 12, 50, 4'h9, 4, 1);
    for (int k = 0; k < 150; k++) begin
      int sp = 2 + int'($urandom_range(18));
      int mc = 1 + int'($urandom_range(78));
      run_cmd(int'($urandom_range(3)), int'($urandom_range(mc)), int'($urandom_range(1)),
              1 + int'($urandom_range(sp - 1)), int'($urandom_range(3)), int'($urandom_range(1)),
              sp, mc, int'($urandom_range(15)), 1 + int'($urandom_range(44)), (k % 10) == 0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule